// File: doc/BRIEF.md
# SPI Register-Access Slave

This block connects a small internal register file to an SPI master. It runs on a fast system clock. The SCK, MOSI and active-low select pins pass through two-flop synchronizers, and SCK edges are found in the system clock domain. The block uses clock mode 0 with the most significant bit first. MOSI is sampled when SCK rises, and MISO changes when SCK falls.

The master opens each transaction with a command byte. Bit 7 of that byte is the direction flag, with 1 for read. Bits 6..0 give the register number. While the command byte is being received, the slave cannot yet know the command, so it shifts out a status byte. On a write, the second byte is stored in the addressed register. On a read, the addressed register is shifted out as the second byte. While the select is high, MISO is not driven, so other slaves can share the line. If the master deasserts the select part-way through a byte, the block drops that byte and records the event. The status byte of the next transaction reports it.

Top module: `spi_reg_slave`

## Requirements
- R1: After reset, every register reads 0x00, the cut-short flag in the status byte is 0, and MISO is not driven.
- R2: While the select pin is high, the block does not drive MISO. Another driver on the shared line is seen unchanged, whether it drives 0 or 1.
- R3: Bits move most significant first. MOSI is sampled on the rising SCK edge, and MISO changes only on the falling SCK edge, so MISO holds steady while SCK is high.
- R4: The first byte shifted out in every transaction is the status byte. Bits 7..4 hold the ID value (0xA by default), bits 3..1 are 0, and bit 0 is the cut-short flag.
- R5: The first byte received is the command. Bit 7 = 1 selects read, bit 7 = 0 selects write, and bits 6..0 give the register address.
- R6: In a write, the second received byte is stored in the register at the command address, for addresses 0..15.
- R7: In a read, the second byte shifted out is the current content of the addressed register, for addresses 0..15.
- R8: Addresses 16..127 reach no register. A write to one of them changes nothing, and a read from one of them returns 0x00.
- R9: Every reply byte after the status byte is 0x00, except the data byte of a valid read. Bytes received after the second byte write nothing.
- R10: If the select rises while a byte is only partly shifted, that byte is discarded and no register is written. The next transaction begins with a fresh command byte aligned to its first SCK edge.
- R11: Status bit 0 is 1 only when the previous transaction ended with a partial byte. A transaction that ends on a byte boundary clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCK |
| rstN | input | 1 | Asynchronous active-low reset |
| sckPin | input | 1 | SPI serial clock from the master, idle low |
| mosiPin | input | 1 | Serial data from the master |
| ssNPin | input | 1 | Active-low slave select |
| misoPin | output | 1 | Serial data to the master; high impedance when not selected |

## Verification
The embedded assertions are checked on every cycle and cover five properties:
- When the select is inactive, no shift, load or register-write strobe fires.
- A select release always leaves the bit and byte counters cleared.
- The cut-short flag rises only after a release in the middle of a byte.
- The registers stay unchanged in any cycle without a write strobe.
- The transmit shifter loads the status byte at the select's falling edge and moves its bits toward the MSB on each falling SCK edge.

Some behaviour only the bench can show, because it needs whole transactions observed at the pins:
- correct bit order
- register contents read back after writes
- zero replies for out-of-range addresses and surplus bytes
- alignment after an aborted byte
- the shared MISO line left undisturbed

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
  localparam int BYTE_W = 8;

  // One-cycle strobes from the control to the datapath
  typedef struct packed {
    logic loadStatus;  // select fell: preload status byte
    logic loadReply;   // byte boundary on falling SCK: preload 0x00
    logic loadRead;    // byte boundary on falling SCK: preload register data
    logic shiftOut;    // falling SCK inside a byte: advance MISO
    logic shiftIn;     // rising SCK: capture MOSI
    logic captureCmd;  // last bit of command byte
    logic writeReg;    // last bit of write data byte
  } spiStrobe_t;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : gStage
      if (g == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) stage[g] <= RESET_VAL;
          else       stage[g] <= din;
      end else begin : gNext
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) stage[g] <= RESET_VAL;
          else       stage[g] <= stage[g-1];
      end
    end
  endgenerate

  assign dout = stage[STAGES-1];
endmodule

// File: rtl/spi_reg_ctrl.sv
module spi_reg_ctrl
  import spi_reg_pkg::*;
#(
  parameter int REG_COUNT = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sckS,
  input  logic              ssNS,
  input  logic [BYTE_W-1:0] cmdByte,
  output spiStrobe_t        st,
  output logic              selActive,
  output logic              abortFlag
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic sckD, ssND;
  logic [CNT_W-1:0] bitCnt;
  logic [1:0] byteIdx;
  logic sckRise, sckFall, ssRise, ssFall, lastBit, atBoundary;
  logic cmdRead, addrOk, readHit;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      sckD <= 1'b0;
      ssND <= 1'b1;
    end else begin
      sckD <= sckS;
      ssND <= ssNS;
    end

  assign selActive  = ~ssNS;
  assign sckRise    = sckS & ~sckD & selActive;
  assign sckFall    = ~sckS & sckD & selActive;
  assign ssFall     = ~ssNS & ssND;
  assign ssRise     = ssNS & ~ssND;
  assign lastBit    = (bitCnt == LAST_BIT);
  assign atBoundary = (bitCnt == '0);

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      bitCnt  <= '0;
      byteIdx <= '0;
    end else if (ssRise || ssFall) begin
      bitCnt  <= '0;
      byteIdx <= '0;
    end else if (sckRise) begin
      bitCnt <= bitCnt + 1'b1;
      if (lastBit && byteIdx != 2'd2) byteIdx <= byteIdx + 1'b1;
    end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)       abortFlag <= 1'b0;
    else if (ssRise) abortFlag <= !atBoundary;

  assign cmdRead = cmdByte[BYTE_W-1];
  assign addrOk  = int'(cmdByte[BYTE_W-2:0]) < REG_COUNT;
  assign readHit = (byteIdx == 2'd1) && cmdRead && addrOk;

  always_comb begin
    st            = '0;
    st.loadStatus = ssFall;
    st.shiftIn    = sckRise;
    st.captureCmd = sckRise && lastBit && (byteIdx == 2'd0);
    st.writeReg   = sckRise && lastBit && (byteIdx == 2'd1) && !cmdRead && addrOk;
    st.shiftOut   = sckFall && !atBoundary;
    st.loadRead   = sckFall && atBoundary && readHit;
    st.loadReply  = sckFall && atBoundary && !readHit;
  end

  // R10: a release always leaves the framing counters at their start
  a_r10_count_cleared: assert property (@(posedge clk) disable iff (!rstN)
    ssRise |=> (bitCnt == '0 && byteIdx == 2'd0));

  // R11: the flag can only be raised by a release in mid-byte
  a_r11_abort_source: assert property (@(posedge clk) disable iff (!rstN)
    $rose(abortFlag) |-> $past(bitCnt) != '0);

  // R2: nothing moves while deselected
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !selActive |-> !(st.shiftIn || st.shiftOut || st.writeReg || st.loadRead));
endmodule

// File: rtl/spi_reg_datapath.sv
module spi_reg_datapath
  import spi_reg_pkg::*;
#(
  parameter int REG_COUNT = 16,
  parameter logic [3:0] ID_NIBBLE = 4'hA
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              mosiS,
  input  spiStrobe_t        st,
  input  logic              abortIn,
  output logic [BYTE_W-1:0] cmdByte,
  output logic              txBit
);
  localparam int ADDR_W = $clog2(REG_COUNT);

  logic [REG_COUNT-1:0][BYTE_W-1:0] regs;
  logic [BYTE_W-2:0] rxShift;
  logic [BYTE_W-1:0] rxByte, txShift, statusByte;
  logic [ADDR_W-1:0] addr;

  assign rxByte     = {rxShift, mosiS};
  assign addr       = cmdByte[ADDR_W-1:0];
  assign statusByte = {ID_NIBBLE, {(BYTE_W-5){1'b0}}, abortIn};

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)           rxShift <= '0;
    else if (st.shiftIn) rxShift <= rxByte[BYTE_W-2:0];

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)              cmdByte <= '0;
    else if (st.captureCmd) cmdByte <= rxByte;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)            regs <= '0;
    else if (st.writeReg) regs[addr] <= rxByte;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)              txShift <= '0;
    else if (st.loadStatus) txShift <= statusByte;
    else if (st.loadRead)   txShift <= regs[addr];
    else if (st.loadReply)  txShift <= '0;
    else if (st.shiftOut)   txShift <= {txShift[BYTE_W-2:0], 1'b0};

  assign txBit = txShift[BYTE_W-1];

  // R6: registers change only under a write strobe
  a_r6_regs_hold: assert property (@(posedge clk) disable iff (!rstN)
    !st.writeReg |=> $stable(regs));

  // R4: selection start presents the status byte
  a_r4_status_load: assert property (@(posedge clk) disable iff (!rstN)
    st.loadStatus |=> txShift == {ID_NIBBLE, {(BYTE_W-5){1'b0}}, abortIn});

  // R3: each falling SCK inside a byte brings the next lower bit to MISO
  a_r3_msb_shift: assert property (@(posedge clk) disable iff (!rstN)
    st.shiftOut |=> txShift[BYTE_W-1] == $past(txShift[BYTE_W-2]));
endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave
  import spi_reg_pkg::*;
#(
  parameter int REG_COUNT = 16,
  parameter logic [3:0] ID_NIBBLE = 4'hA
) (
  input  logic clk,
  input  logic rstN,
  input  logic sckPin,
  input  logic mosiPin,
  input  logic ssNPin,
  output logic misoPin
);
  logic [2:0] pinsS;
  logic sckS, mosiS, ssNS;
  spiStrobe_t st;
  logic selActive, abortFlag, txBit;
  logic [BYTE_W-1:0] cmdByte;

  spi_pin_sync #(.WIDTH(3), .STAGES(2), .RESET_VAL(3'b100)) u_sync (
    .clk (clk),
    .rstN(rstN),
    .din ({ssNPin, mosiPin, sckPin}),
    .dout(pinsS)
  );
  assign {ssNS, mosiS, sckS} = pinsS;

  spi_reg_ctrl #(.REG_COUNT(REG_COUNT)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .sckS     (sckS),
    .ssNS     (ssNS),
    .cmdByte  (cmdByte),
    .st       (st),
    .selActive(selActive),
    .abortFlag(abortFlag)
  );

  spi_reg_datapath #(.REG_COUNT(REG_COUNT), .ID_NIBBLE(ID_NIBBLE)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .mosiS  (mosiS),
    .st     (st),
    .abortIn(abortFlag),
    .cmdByte(cmdByte),
    .txBit  (txBit)
  );

  assign misoPin = selActive ? txBit : 1'bz;
endmodule

// File: tb/spi_reg_slave_tb.sv
`timescale 1ns/1ps
module spi_reg_slave_tb;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sckPin = 1'b0, mosiPin = 1'b0, ssNPin = 1'b1;
  logic otherEn = 1'b0, otherVal = 1'b0;
  wire  misoBus;

  int checks = 0, failures = 0;
  bit done = 1'b0;
  logic [7:0] model [16];
  logic lastAbort = 1'b0;

  always #10 clk = ~clk;

  assign misoBus = otherEn ? otherVal : 1'bz;

  spi_reg_slave u_dut (
    .clk(clk), .rstN(rstN), .sckPin(sckPin), .mosiPin(mosiPin),
    .ssNPin(ssNPin), .misoPin(misoBus)
  );

  function automatic logic [7:0] statusExp(input logic ab);
    return {4'hA, 3'b000, ab};
  endfunction

  function automatic logic [7:0] readExp(input int a);
    return (a < 16) ? model[a] : 8'h00;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
    rx = 8'h00;
    for (int i = 0; i < nbits; i++) begin
      mosiPin = tx[7-i];
      repeat (HALF) @(negedge clk);
      rx[7-i] = misoBus;
      sckPin = 1'b1;
      repeat (HALF - 1) @(negedge clk);
      chk("R3 MISO steady while SCK high", int'(misoBus), int'(rx[7-i]));
      @(negedge clk);
      sckPin = 1'b0;
    end
  endtask

  task automatic run(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2,
                     input int nBytes, input int lastBits,
                     output logic [7:0] r0, output logic [7:0] r1, output logic [7:0] r2);
    logic [7:0] tx [3];
    logic [7:0] rx [3];
    tx[0] = b0; tx[1] = b1; tx[2] = b2;
    rx[0] = 8'h00; rx[1] = 8'h00; rx[2] = 8'h00;
    ssNPin = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int b = 0; b < nBytes; b++)
      xfer(tx[b], (b == nBytes - 1) ? lastBits : 8, rx[b]);
    repeat (HALF) @(negedge clk);
    ssNPin = 1'b1;
    repeat (2 * HALF) @(negedge clk);
    r0 = rx[0]; r1 = rx[1]; r2 = rx[2];
  endtask

  task automatic doWrite(input int a, input logic [7:0] d, input string req);
    logic [7:0] r0, r1, r2;
    run({1'b0, 7'(a)}, d, 8'h00, 2, 8, r0, r1, r2);
    chk({req, " R4 status on write"}, int'(r0), int'(statusExp(lastAbort)));
    chk({req, " R9 write data reply zero"}, int'(r1), 0);
    if (a < 16) model[a] = d;
    lastAbort = 1'b0;
  endtask

  task automatic doRead(input int a, input string req);
    logic [7:0] r0, r1, r2;
    run({1'b1, 7'(a)}, 8'($urandom), 8'h00, 2, 8, r0, r1, r2);
    chk({req, " R4 status on read"}, int'(r0), int'(statusExp(lastAbort)));
    chk({req, " R5 R7 read data"}, int'(r1), int'(readExp(a)));
    lastAbort = 1'b0;
  endtask

  task automatic checkShared(input string req);
    for (int v = 0; v < 2; v++) begin
      otherVal = v[0];
      otherEn = 1'b1;
      repeat (3) @(negedge clk);
      chk({req, " R2 shared MISO undisturbed"}, int'(misoBus), v);
      otherEn = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] r0, r1, r2;
    void'($urandom(32'd4242));
    for (int i = 0; i < 16; i++) model[i] = 8'h00;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    checkShared("R1 after reset");
    doRead(3, "R1 reset register");
    doRead(15, "R1 reset register");

    // R3 bit order with asymmetric values, top address
    doWrite(15, 8'h81, "R6 addr 15");
    doWrite(0, 8'h3C, "R6 addr 0");
    doWrite(7, 8'h01, "R6 lsb only");
    doRead(15, "R3 R7 asym");
    doRead(7, "R3 R7 lsb");
    doRead(0, "R7 addr 0");
    checkShared("R2 after transactions");

    // R8 out-of-range addresses
    doWrite(16, 8'hFF, "R8 write 16");
    doWrite(127, 8'hEE, "R8 write 127");
    doRead(16, "R8 read 16");
    doRead(127, "R8 read 127");
    doRead(0, "R8 addr 0 untouched");

    // R9 surplus third byte
    run({1'b0, 7'd4}, 8'h5A, 8'hA7, 3, 8, r0, r1, r2);
    chk("R9 status", int'(r0), int'(statusExp(lastAbort)));
    chk("R9 second reply", int'(r1), 0);
    chk("R9 third reply", int'(r2), 0);
    model[4] = 8'h5A;
    lastAbort = 1'b0;
    doRead(4, "R9 written once");
    doRead(5, "R9 neighbour untouched");
    run({1'b1, 7'd4}, 8'h00, 8'h00, 3, 8, r0, r1, r2);
    chk("R9 read third byte zero", int'(r2), 0);
    chk("R7 read in 3-byte txn", int'(r1), int'(model[4]));

    // R10 R11 abort in data byte of a write
    run({1'b0, 7'd4}, 8'h11, 8'h00, 2, 5, r0, r1, r2);
    chk("R10 status before abort", int'(r0), int'(statusExp(1'b0)));
    lastAbort = 1'b1;
    doRead(4, "R10 R11 no partial write");
    doRead(4, "R11 flag cleared");

    // R10 abort inside command byte, then aligned full write
    run(8'h03, 8'h00, 8'h00, 1, 3, r0, r1, r2);
    lastAbort = 1'b1;
    doWrite(9, 8'hC5, "R10 R11 aligned after abort");
    doRead(9, "R10 aligned readback");

    // Random mix
    for (int n = 0; n < 50; n++) begin
      int op, a;
      logic [7:0] d;
      op = $urandom_range(0, 4);
      a  = $urandom_range(0, 19);
      d  = 8'($urandom);
      if (op < 2) doWrite(a, d, "R6 R8 random write");
      else if (op < 4) doRead(a, "R7 R8 random read");
      else begin
        int bits;
        bits = $urandom_range(1, 7);
        if ($urandom_range(0, 1) == 1) begin
          run({1'b0, 7'(a)}, d, 8'h00, 2, bits, r0, r1, r2);
          chk("R11 status in aborted txn", int'(r0), int'(statusExp(lastAbort)));
        end else begin
          run({1'b0, 7'(a)}, d, 8'h00, 1, bits, r0, r1, r2);
        end
        lastAbort = 1'b1;
      end
    end
    doRead(2, "R11 final");
    checkShared("R2 final");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule